// File: doc/BRIEF.md
# Packed Four-Byte Transfer Buffer

This block keeps up to four bytes in one 32-bit word. A transmit byte count and a receive byte count track how much of the word each direction owns. On the host side it faces a 16-bit data register. A host write of 16 or 8 bits shifts the word left and places the new bytes at the bottom. A host read of 16 bits takes the two lowest lanes and moves the remaining received bytes down.

On the serial side it faces a byte-wide engine. When the engine pops, it receives the oldest transmit byte. When the engine pushes, the received byte is merged into the next free lane. A control input selects the byte order of 16-bit host accesses.

The block reports ready, underflow, overrun and single-byte conditions to the surrounding status logic. A start input marks a new bus transfer and clears the word.

Top module: `pkbuf_top`

## Requirements
- R1: After reset the word, both counts and all five flags are zero, so `rdata_o` and `pop_data_o` read 0.
- R2: A 16-bit write (`wr16_i`) is dropped when the transmit count, after any same-cycle pop, exceeds 2. Otherwise the word shifts left by 16 bits, the transmit count rises by 2 and the low half is loaded. With `big_end_i`=1, `wdata_i[15:8]` goes to bits 15:8 and `wdata_i[7:0]` to bits 7:0; with `big_end_i`=0 the two bytes are swapped. `wr16_i` has priority over `wr8_i`.
- R3: An 8-bit write (`wr8_i` without `wr16_i`) obeys the same guard. When accepted, it shifts the word left by 8 bits, places `wdata_i[7:0]` in bits 7:0 and raises the transmit count by 1.
- R4: `pop_data_o` always shows byte lane (transmit count − 1), where lane k is bits 8k+7:8k, or 0 when the count is zero. A pop decrements a nonzero count. A pop at count zero sets `tx_udf_o`.
- R5: A push ORs `push_data_i` into lane (receive count) and increments the count. If the count is already 4, the word and the count are unchanged and `rx_ovr_o` is set.
- R6: `rdata_o` shows lanes 0 and 1. With `big_end_i`=1, lane 0 is in bits 15:8; with `big_end_i`=0, lane 0 is in bits 7:0.
- R7: A read at receive count 1 sets `single_o` and clears the count. A read at count above 2 shifts the word right by 16 bits. A read at count above 1 lowers the count by 2. A read at count 0 changes neither the word nor the count.
- R8: Flag updates:
  - Any host write, accepted or not, clears `tx_udf_o`.
  - Every pop sets `tx_rdy_o`; an accepted write that leaves more than 2 transmit bytes clears it.
  - Every read clears `rx_ovr_o`.
  - Every push sets `rx_rdy_o`; a read that leaves the receive count at 0 clears it.
- R9: `start_i` zeroes the word and clears `single_o`, and leaves both counts unchanged.
- R10: Events in one cycle apply in a fixed order: start, then pop, then write, then read, then push. Each sees the result of the previous one, and a later flag update overrides an earlier one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | New transfer: clear word and single-byte flag |
| big_end_i | input | 1 | Byte order of 16-bit host accesses |
| wr16_i | input | 1 | Host 16-bit write strobe |
| wr8_i | input | 1 | Host 8-bit write strobe |
| wdata_i | input | 16 | Host write data |
| pop_i | input | 1 | Engine takes one transmit byte |
| pop_data_o | output | 8 | Next transmit byte |
| push_i | input | 1 | Engine delivers one received byte |
| push_data_i | input | 8 | Received byte |
| rd_i | input | 1 | Host 16-bit read strobe |
| rdata_o | output | 16 | Host read data |
| tx_count_o | output | 3 | Transmit bytes held |
| rx_count_o | output | 3 | Receive bytes held |
| tx_rdy_o | output | 1 | Transmit ready |
| tx_udf_o | output | 1 | Transmit underflow |
| rx_rdy_o | output | 1 | Receive ready |
| rx_ovr_o | output | 1 | Receive overrun |
| single_o | output | 1 | A read found only one byte |

## Verification
Two pairs of functions can coincide in a cycle, and each pair touches the same flag or count:
- A host read can meet an engine push, for example a read of a full receive side together with a push. The read must drain first so that the push lands in lane 2 and `rx_rdy_o` stays set.
- A pop can meet a host write, for example a pop at a transmit count of 3 together with a 16-bit write. The pop must lower the count first so that the write is accepted and the count ends at 4.

Directed cycles provoke both collisions, and long random runs with all strobes independent provoke them again. A behavioural byte-list model in the bench applies the order of R10 and judges every output on every clock.

// File: rtl/pkbuf_pkg.sv
package pkbuf_pkg;
  localparam int BYTE_W = 8;
  localparam int LANES = 4;
  localparam int HOST_LANES = 2;
  localparam int WORD_W = BYTE_W * LANES;
  localparam int HOST_W = BYTE_W * HOST_LANES;
  localparam int CNT_W = $clog2(LANES + 1);
  localparam int WR_LIMIT = LANES - HOST_LANES;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [HOST_W-1:0] half_t;

  function automatic byte_t lane_get(word_t w, cnt_t idx);
    byte_t r;
    r = '0;
    for (int i = 0; i < LANES; i++)
      if (cnt_t'(i) == idx) r = w[i*BYTE_W +: BYTE_W];
    return r;
  endfunction

  function automatic word_t lane_or(word_t w, cnt_t idx, byte_t b);
    word_t r;
    r = w;
    for (int i = 0; i < LANES; i++)
      if (cnt_t'(i) == idx) r[i*BYTE_W +: BYTE_W] = w[i*BYTE_W +: BYTE_W] | b;
    return r;
  endfunction

  function automatic half_t swap_pair(half_t v);
    return {v[BYTE_W-1:0], v[HOST_W-1:BYTE_W]};
  endfunction
endpackage

// File: rtl/pkbuf_tx_path.sv
module pkbuf_tx_path
  import pkbuf_pkg::*;
(
  input  word_t word_i,
  input  cnt_t  cnt_i,
  input  logic  pop_i,
  input  logic  wr16_i,
  input  logic  wr8_i,
  input  logic  be_i,
  input  half_t wdata_i,
  output byte_t pop_byte_o,
  output word_t word_o,
  output cnt_t  cnt_o,
  output logic  pop_empty_o,
  output logic  wr_drop_o,
  output logic  wr_fill_o
);
  cnt_t cnt_p;
  logic wr_any;
  logic wr_take;

  always_comb begin
    pop_byte_o  = (cnt_i == '0) ? '0 : lane_get(word_i, cnt_i - cnt_t'(1));
    pop_empty_o = pop_i && (cnt_i == '0);
    cnt_p       = (pop_i && cnt_i != '0) ? cnt_i - cnt_t'(1) : cnt_i;
    wr_any      = wr16_i || wr8_i;
    wr_drop_o   = wr_any && (cnt_p > cnt_t'(WR_LIMIT));
    wr_take     = wr_any && !wr_drop_o;
    word_o      = word_i;
    cnt_o       = cnt_p;
    if (wr_take) begin
      if (wr16_i) begin
        word_o = (word_i << HOST_W) | word_t'(be_i ? wdata_i : swap_pair(wdata_i));
        cnt_o  = cnt_p + cnt_t'(HOST_LANES);
      end else begin
        word_o = (word_i << BYTE_W) | word_t'(wdata_i[BYTE_W-1:0]);
        cnt_o  = cnt_p + cnt_t'(1);
      end
    end
    wr_fill_o = wr_take && (cnt_o > cnt_t'(WR_LIMIT));
  end
endmodule

// File: rtl/pkbuf_rx_path.sv
module pkbuf_rx_path
  import pkbuf_pkg::*;
(
  input  word_t word_i,
  input  cnt_t  cnt_i,
  input  logic  rd_i,
  input  logic  push_i,
  input  byte_t push_byte_i,
  input  logic  be_i,
  output half_t rdata_o,
  output word_t word_o,
  output cnt_t  cnt_o,
  output logic  rd_single_o,
  output logic  rd_zero_o,
  output logic  push_drop_o
);
  word_t w_r;
  cnt_t  c_r;

  always_comb begin
    rdata_o     = be_i ? swap_pair(word_i[HOST_W-1:0]) : word_i[HOST_W-1:0];
    w_r         = word_i;
    c_r         = cnt_i;
    rd_single_o = rd_i && (cnt_i == cnt_t'(1));
    if (rd_i) begin
      if (cnt_i == cnt_t'(1)) c_r = '0;
      else if (cnt_i > cnt_t'(1)) begin
        if (cnt_i > cnt_t'(HOST_LANES)) w_r = word_i >> HOST_W;
        c_r = cnt_i - cnt_t'(HOST_LANES);
      end
    end
    rd_zero_o   = rd_i && (c_r == '0);
    push_drop_o = push_i && (c_r == cnt_t'(LANES));
    word_o      = w_r;
    cnt_o       = c_r;
    if (push_i && !push_drop_o) begin
      word_o = lane_or(w_r, c_r, push_byte_i);
      cnt_o  = c_r + cnt_t'(1);
    end
  end
endmodule

// File: rtl/pkbuf_flags.sv
module pkbuf_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic pop_i,
  input  logic pop_empty_i,
  input  logic wr_any_i,
  input  logic wr_fill_i,
  input  logic rd_i,
  input  logic rd_zero_i,
  input  logic rd_single_i,
  input  logic push_i,
  input  logic push_drop_i,
  output logic tx_rdy_o,
  output logic tx_udf_o,
  output logic rx_rdy_o,
  output logic rx_ovr_o,
  output logic single_o
);
  logic tx_rdy_d, tx_udf_d, rx_rdy_d, rx_ovr_d, single_d;

  always_comb begin
    tx_udf_d = tx_udf_o;
    if (pop_empty_i) tx_udf_d = 1'b1;
    if (wr_any_i)    tx_udf_d = 1'b0;
    tx_rdy_d = tx_rdy_o;
    if (pop_i)       tx_rdy_d = 1'b1;
    if (wr_fill_i)   tx_rdy_d = 1'b0;
    rx_ovr_d = rx_ovr_o;
    if (rd_i)        rx_ovr_d = 1'b0;
    if (push_drop_i) rx_ovr_d = 1'b1;
    rx_rdy_d = rx_rdy_o;
    if (rd_zero_i)   rx_rdy_d = 1'b0;
    if (push_i)      rx_rdy_d = 1'b1;
    single_d = single_o;
    if (start_i)     single_d = 1'b0;
    if (rd_single_i) single_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_rdy_o <= 1'b0;
      tx_udf_o <= 1'b0;
      rx_rdy_o <= 1'b0;
      rx_ovr_o <= 1'b0;
      single_o <= 1'b0;
    end else begin
      tx_rdy_o <= tx_rdy_d;
      tx_udf_o <= tx_udf_d;
      rx_rdy_o <= rx_rdy_d;
      rx_ovr_o <= rx_ovr_d;
      single_o <= single_d;
    end
  end
endmodule

// File: rtl/pkbuf_top.sv
module pkbuf_top
  import pkbuf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        big_end_i,
  input  logic        wr16_i,
  input  logic        wr8_i,
  input  logic [15:0] wdata_i,
  input  logic        pop_i,
  output logic [7:0]  pop_data_o,
  input  logic        push_i,
  input  logic [7:0]  push_data_i,
  input  logic        rd_i,
  output logic [15:0] rdata_o,
  output logic [2:0]  tx_count_o,
  output logic [2:0]  rx_count_o,
  output logic        tx_rdy_o,
  output logic        tx_udf_o,
  output logic        rx_rdy_o,
  output logic        rx_ovr_o,
  output logic        single_o
);
  word_t word_q, word_s, word_t1, word_r1;
  cnt_t  txc_q, rxc_q, txc_d, rxc_d;
  logic  pop_empty, wr_drop, wr_fill, rd_single, rd_zero, push_drop;

  assign word_s = start_i ? '0 : word_q;

  pkbuf_tx_path u_tx (
    .word_i(word_s), .cnt_i(txc_q), .pop_i(pop_i), .wr16_i(wr16_i), .wr8_i(wr8_i),
    .be_i(big_end_i), .wdata_i(wdata_i), .pop_byte_o(pop_data_o), .word_o(word_t1),
    .cnt_o(txc_d), .pop_empty_o(pop_empty), .wr_drop_o(wr_drop), .wr_fill_o(wr_fill)
  );

  pkbuf_rx_path u_rx (
    .word_i(word_t1), .cnt_i(rxc_q), .rd_i(rd_i), .push_i(push_i),
    .push_byte_i(push_data_i), .be_i(big_end_i), .rdata_o(rdata_o), .word_o(word_r1),
    .cnt_o(rxc_d), .rd_single_o(rd_single), .rd_zero_o(rd_zero), .push_drop_o(push_drop)
  );

  pkbuf_flags u_flags (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pop_i(pop_i), .pop_empty_i(pop_empty),
    .wr_any_i(wr16_i | wr8_i), .wr_fill_i(wr_fill), .rd_i(rd_i), .rd_zero_i(rd_zero),
    .rd_single_i(rd_single), .push_i(push_i), .push_drop_i(push_drop),
    .tx_rdy_o(tx_rdy_o), .tx_udf_o(tx_udf_o), .rx_rdy_o(rx_rdy_o), .rx_ovr_o(rx_ovr_o),
    .single_o(single_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      txc_q  <= '0;
      rxc_q  <= '0;
    end else begin
      word_q <= word_r1;
      txc_q  <= txc_d;
      rxc_q  <= rxc_d;
    end
  end

  assign tx_count_o = txc_q;
  assign rx_count_o = rxc_q;
endmodule

// File: rtl/pkbuf_chk.sv
module pkbuf_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr16_i,
  input logic       wr8_i,
  input logic       pop_i,
  input logic       push_i,
  input logic       rd_i,
  input logic [2:0] tx_count_o,
  input logic [2:0] rx_count_o,
  input logic       tx_udf_o,
  input logic       rx_ovr_o,
  input logic       rx_rdy_o,
  input logic       single_o,
  input logic       wr_drop,
  input logic       push_drop
);
  AST_TX_RANGE: assert property (@(posedge clk) disable iff (!rst_n) tx_count_o <= 3'd4); // R2
  AST_RX_RANGE: assert property (@(posedge clk) disable iff (!rst_n) rx_count_o <= 3'd4); // R5
  AST_WR_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drop && !pop_i |=> tx_count_o == $past(tx_count_o)); // R2
  AST_EMPTY_POP_UDF: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i && tx_count_o == 3'd0 && !wr16_i && !wr8_i |=> tx_udf_o); // R4
  AST_FULL_PUSH_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop |=> rx_ovr_o && rx_count_o == 3'd4); // R5
  AST_LONE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i && rx_count_o == 3'd1 |=> single_o); // R7
  AST_WR_CLR_UDF: assert property (@(posedge clk) disable iff (!rst_n)
    wr16_i || wr8_i |=> !tx_udf_o); // R8
  AST_RD_CLR_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i && !push_i |=> !rx_ovr_o); // R8
  AST_PUSH_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |=> rx_rdy_o); // R10
endmodule

bind pkbuf_top pkbuf_chk u_chk (.*);

// File: tb/sim_pkbuf_top.sv
`timescale 1ns/1ps
module sim_pkbuf_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 0, big_end_i = 0, wr16_i = 0, wr8_i = 0, pop_i = 0, push_i = 0, rd_i = 0;
  logic [15:0] wdata_i = '0;
  logic [7:0]  push_data_i = '0;
  logic [7:0]  pop_data_o;
  logic [15:0] rdata_o;
  logic [2:0]  tx_count_o, rx_count_o;
  logic tx_rdy_o, tx_udf_o, rx_rdy_o, rx_ovr_o, single_o;

  int total = 0, bad = 0;
  bit done = 0;
  int mb[4];
  int mtc = 0, mrc = 0, m_trdy = 0, m_udf = 0, m_rrdy = 0, m_ovr = 0, m_sgl = 0;
  int last_pop = 0, last_rd = 0;

  always #10 clk = ~clk;

  pkbuf_top u0 (.*);

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference: byte list with lane 0 at index 0
  task automatic model(output int ep, output int er);
    if (start_i) begin
      foreach (mb[k]) mb[k] = 0;
      m_sgl = 0;
    end
    ep = (mtc == 0) ? 0 : mb[mtc-1];
    if (pop_i) begin
      m_trdy = 1;
      if (mtc == 0) m_udf = 1; else mtc--;
    end
    if (wr16_i || wr8_i) begin
      m_udf = 0;
      if (mtc <= 2) begin
        if (wr16_i) begin
          mb[3] = mb[1]; mb[2] = mb[0];
          mb[1] = big_end_i ? wdata_i[15:8] : wdata_i[7:0];
          mb[0] = big_end_i ? wdata_i[7:0] : wdata_i[15:8];
          mtc += 2;
        end else begin
          mb[3] = mb[2]; mb[2] = mb[1]; mb[1] = mb[0]; mb[0] = wdata_i[7:0];
          mtc += 1;
        end
        if (mtc > 2) m_trdy = 0;
      end
    end
    er = big_end_i ? (mb[0] * 256 + mb[1]) : (mb[1] * 256 + mb[0]);
    if (rd_i) begin
      m_ovr = 0;
      case (mrc)
        0: ;
        1: begin m_sgl = 1; mrc = 0; end
        2: mrc = 0;
        default: begin mb[0] = mb[2]; mb[1] = mb[3]; mb[2] = 0; mb[3] = 0; mrc -= 2; end
      endcase
      if (mrc == 0) m_rrdy = 0;
    end
    if (push_i) begin
      m_rrdy = 1;
      if (mrc == 4) m_ovr = 1;
      else begin mb[mrc] = mb[mrc] | push_data_i; mrc++; end
    end
  endtask

  task automatic step();
    int ep, er;
    #2;
    model(ep, er);
    last_pop = pop_data_o;
    last_rd = rdata_o;
    chk("R4 pop_data", pop_data_o, ep);
    chk("R6 rdata", rdata_o, er);
    @(negedge clk);
    chk("R2 tx_count", tx_count_o, mtc);
    chk("R7 rx_count", rx_count_o, mrc);
    chk("R8 tx_rdy", tx_rdy_o, m_trdy);
    chk("R4 tx_udf", tx_udf_o, m_udf);
    chk("R8 rx_rdy", rx_rdy_o, m_rrdy);
    chk("R5 rx_ovr", rx_ovr_o, m_ovr);
    chk("R7 single", single_o, m_sgl);
    {start_i, wr16_i, wr8_i, pop_i, push_i, rd_i} = '0;
  endtask

  task automatic w16(logic [15:0] d); wr16_i = 1; wdata_i = d; step(); endtask
  task automatic w8(logic [7:0] d);   wr8_i = 1; wdata_i = {8'h00, d}; step(); endtask
  task automatic pop1();               pop_i = 1; step(); endtask
  task automatic push1(logic [7:0] d); push_i = 1; push_data_i = d; step(); endtask
  task automatic rd1();                rd_i = 1; step(); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    foreach (mb[k]) mb[k] = 0;
    repeat (2) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 tx_count", tx_count_o, 0); chk("R1 rx_count", rx_count_o, 0);
    chk("R1 rdata", rdata_o, 0); chk("R1 pop_data", pop_data_o, 0);
    chk("R1 flags", {tx_rdy_o, tx_udf_o, rx_rdy_o, rx_ovr_o, single_o}, 0);
    @(negedge clk); rst_n = 1; @(negedge clk);

    big_end_i = 1;
    w16(16'hA1B2);
    chk("R2 count after 16-bit write", tx_count_o, 2);
    #2 chk("R2 big-end lane1", pop_data_o, 8'hA1); @(negedge clk);
    w8(8'hC3);
    chk("R3 count after 8-bit write", tx_count_o, 3);
    w16(16'h5555);
    chk("R2 dropped write keeps count", tx_count_o, 3);
    pop1(); chk("R4 oldest first", last_pop, 8'hA1);
    pop1(); chk("R4 second", last_pop, 8'hB2);
    pop1(); chk("R4 third", last_pop, 8'hC3);
    pop1(); chk("R4 empty pop gives zero", last_pop, 0);
    chk("R4 underflow set", tx_udf_o, 1);
    big_end_i = 0;
    w16(16'h1234);
    chk("R8 write clears underflow", tx_udf_o, 0);
    #2 chk("R2 little-end swap lane1", pop_data_o, 8'h34); @(negedge clk);
    pop1(); pop1();

    start_i = 1; step();
    chk("R9 start clears word", rdata_o, 0);
    chk("R9 start keeps tx count", tx_count_o, 0);
    push1(8'h11); push1(8'h22); push1(8'h33);
    #2 chk("R6 little-end read", rdata_o, 16'h2211);
    big_end_i = 1; #1 chk("R6 big-end read", rdata_o, 16'h1122); big_end_i = 0;
    @(negedge clk);
    rd1(); chk("R7 count 3 -> 1", rx_count_o, 1);
    #2 chk("R7 shifted down", rdata_o, 16'h0033); @(negedge clk);
    rd1(); chk("R7 lone byte flag", single_o, 1);
    chk("R8 rx ready cleared", rx_rdy_o, 0);
    start_i = 1; step();
    chk("R9 start clears single", single_o, 0);
    push1(8'h01); push1(8'h02); push1(8'h03); push1(8'h04); push1(8'h05);
    chk("R5 overrun", rx_ovr_o, 1);
    chk("R5 count stays 4", rx_count_o, 4);
    rd_i = 1; push_i = 1; push_data_i = 8'h80; step();
    chk("R10 read then push count", rx_count_o, 3);
    chk("R8 read clears overrun", rx_ovr_o, 0);
    #2 chk("R10 push lands lane2", rdata_o, 16'h0403); @(negedge clk);
    rd1();
    #2 chk("R10 lane2 byte", rdata_o[7:0], 8'h80); @(negedge clk);
    rd1();
    w8(8'h10); w16(16'h2030);
    pop_i = 1; wr16_i = 1; wdata_i = 16'h4050; step();
    chk("R10 pop then write accepted", tx_count_o, 4);
    pop1(); pop1(); pop1(); pop1();

    for (int i = 0; i < 4000; i++) begin
      start_i = ($urandom_range(0, 40) == 0);
      big_end_i = $urandom_range(0, 1);
      wr16_i = ($urandom_range(0, 4) == 0);
      wr8_i = ($urandom_range(0, 5) == 0);
      wdata_i = 16'($urandom);
      pop_i = ($urandom_range(0, 2) == 0);
      push_i = ($urandom_range(0, 2) == 0);
      push_data_i = 8'($urandom);
      rd_i = ($urandom_range(0, 3) == 0);
      step();
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule